// File: doc/BRIEF.md
# Load/Store Data Formatting Unit

This unit sits between a 64-bit register file and a little-endian, byte-addressed data memory port. It accepts one load or store operation at a time and forms the effective address. For a store it places the low-order bytes of the source register, or a sign-extended immediate, into the right byte lanes and drives the lane enables. For a load it gathers the addressed bytes and writes back a full 64-bit value, either zero-extended or sign-extended.

The memory port is 64 bits wide and uses a valid/ready request handshake. Read data returns one cycle after a read beat is accepted. An access that crosses an 8-byte boundary is split into two beats. Only the low 32 bits of a register-sourced address take part, so addresses wrap modulo 2^32.

Top module: `lsu_fmt`

## Requirements
- R1: With `op_indirect_i`=1 the effective address is `base_i[31:0]` plus the sign-extended `offset_i`, modulo 2^32, and `base_i[63:32]` has no effect. With `op_indirect_i`=0 the effective address is `offset_i`.
- R2: Every beat address has bits [2:0] equal to zero. The first beat address is the effective address with bits [2:0] cleared. Lane k of `mem_be_o`, `mem_wdata_o[8k+7:8k]` and `mem_rdata_i[8k+7:8k]` carries the byte at beat address + k.
- R3: `op_size_i` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The enabled lanes are contiguous and start at lane EA[2:0]. When EA[2:0] + bytes > 8, a second beat follows at the first beat address + 8 (mod 2^32) and enables the remaining bytes from lane 0.
- R4: A register store writes only the low `bytes` bytes of `src_i`, in ascending address order. Memory bytes beyond the access, including the upper half of the register for a 4-byte store, stay untouched.
- R5: With `op_imm_data_i`=1 the store data is `src_imm_i` sign-extended to 64 bits, then stored according to the size.
- R6: A load with `op_signed_i`=1 and size code 0, 1 or 2 sign-extends to 64 bits. With `op_signed_i`=0 it zero-extends. Size code 3 returns the 8 bytes unmodified. The writeback always defines all 64 bits.
- R7: A split load assembles its result from both beats in ascending byte order.
- R8: While `mem_valid_o` is high and `mem_ready_i` is low, the request holds with a stable address, enables and data. `op_ready_o` is high only when no operation is in progress. `mem_we_o` is high exactly on store beats.
- R9: `wb_valid_o` is a one-cycle pulse. It is high in the second cycle after the clock edge that accepts a load's final beat. Stores produce no pulse.
- R10: After reset `op_ready_o`=1, `mem_valid_o`=0 and `wb_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request |
| op_ready_o | output | 1 | Unit idle, operation accepted |
| op_store_i | input | 1 | 1 = store, 0 = load |
| op_size_i | input | 2 | Access size code (1/2/4/8 bytes) |
| op_signed_i | input | 1 | Sign-extend load result |
| op_indirect_i | input | 1 | Address = base + offset |
| op_imm_data_i | input | 1 | Store data from immediate |
| base_i | input | 64 | Base register value |
| offset_i | input | 32 | Address offset or absolute address |
| src_i | input | 64 | Store source register |
| src_imm_i | input | 32 | Store immediate |
| mem_valid_o | output | 1 | Memory beat request |
| mem_ready_i | input | 1 | Memory accepts beat |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | 8-byte aligned beat address |
| mem_be_o | output | 8 | Lane enables |
| mem_wdata_o | output | 64 | Write lanes |
| mem_rdata_i | input | 64 | Read lanes, one cycle after accept |
| wb_valid_o | output | 1 | Load result valid |
| wb_data_o | output | 64 | 64-bit load result |

## Verification
On a split load, the first beat's read data arrives in the same cycle that the second beat is requested. A stall on that second request leaves the data on the bus for only that one cycle. Unaligned loads crossing the 8-byte boundary are issued with the memory model's ready signal both held high and toggling every cycle. The bench judges the assembled writeback against a byte-level model of memory and checks the writeback timing relative to the final accept.

// File: rtl/lsu_fmt_pkg.sv
package lsu_fmt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ0 = 2'd1,
    ST_REQ1 = 2'd2,
    ST_WAIT = 2'd3
  } state_e;
endpackage

// File: rtl/lsu_fmt_addr.sv
module lsu_fmt_addr #(
  parameter int AW   = 32,
  parameter int IMMW = 32
) (
  input  logic            indirect_i,
  input  logic [AW-1:0]   base_i,
  input  logic [IMMW-1:0] offset_i,
  output logic [AW-1:0]   ea_o
);
  logic [AW-1:0] off_ext;
  assign off_ext = AW'($signed(offset_i));
  // modulo 2^AW by width
  assign ea_o = (indirect_i ? base_i : '0) + off_ext;
endmodule

// File: rtl/lsu_fmt_store.sv
module lsu_fmt_store #(
  parameter  int XLEN  = 64,
  localparam int LANES = XLEN / 8,
  localparam int OFFW  = $clog2(LANES),
  localparam int SZW   = $clog2(OFFW + 1)
) (
  input  logic [XLEN-1:0]    data_i,
  input  logic [OFFW-1:0]    off_i,
  input  logic [SZW-1:0]     size_i,
  output logic [2*LANES-1:0] be_o,
  output logic [2*XLEN-1:0]  wdata_o
);
  logic [2*LANES-1:0] mask;
  assign mask    = ((2*LANES)'(1) << (1 << size_i)) - (2*LANES)'(1);
  assign be_o    = mask << off_i;
  assign wdata_o = {{XLEN{1'b0}}, data_i} << {off_i, 3'b000};
endmodule

// File: rtl/lsu_fmt_load.sv
module lsu_fmt_load #(
  parameter  int XLEN  = 64,
  localparam int LANES = XLEN / 8,
  localparam int OFFW  = $clog2(LANES),
  localparam int SZW   = $clog2(OFFW + 1)
) (
  input  logic [2*XLEN-1:0] beats_i,
  input  logic [OFFW-1:0]   off_i,
  input  logic [SZW-1:0]    size_i,
  input  logic              sgn_i,
  output logic [XLEN-1:0]   val_o
);
  logic [2*XLEN-1:0] sh;
  logic              unused_hi;
  assign sh        = beats_i >> {off_i, 3'b000};
  assign unused_hi = ^sh[2*XLEN-1:XLEN];

  always_comb begin
    int nb;
    logic msb;
    nb    = 8 << size_i;
    msb   = sh[nb-1];
    val_o = sh[XLEN-1:0];
    for (int i = 0; i < XLEN; i++)
      if (i >= nb) val_o[i] = sgn_i & msb;
  end
endmodule

// File: rtl/lsu_fmt.sv
module lsu_fmt
  import lsu_fmt_pkg::*;
#(
  parameter  int XLEN  = 64,
  parameter  int AW    = 32,
  parameter  int IMMW  = 32,
  localparam int LANES = XLEN / 8,
  localparam int OFFW  = $clog2(LANES),
  localparam int SZW   = $clog2(OFFW + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  output logic            op_ready_o,
  input  logic            op_store_i,
  input  logic [SZW-1:0]  op_size_i,
  input  logic            op_signed_i,
  input  logic            op_indirect_i,
  input  logic            op_imm_data_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [IMMW-1:0] offset_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [IMMW-1:0] src_imm_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [LANES-1:0] mem_be_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            wb_valid_o,
  output logic [XLEN-1:0] wb_data_o
);
  state_e          state_q;
  logic [AW-1:0]   ea_d, ea_q, beat_addr;
  logic [SZW-1:0]  size_q;
  logic            sgn_q, store_q, rd_pend_q, wb_valid_q, split;
  logic [XLEN-1:0] data_q, lo_q, wb_data_q, ld_val;
  logic [2*LANES-1:0] be_wide;
  logic [2*XLEN-1:0]  wd_wide, ld_beats;
  logic            unused_base;

  assign unused_base = ^base_i[XLEN-1:AW];

  lsu_fmt_addr #(.AW(AW), .IMMW(IMMW)) u_addr (
    .indirect_i(op_indirect_i), .base_i(base_i[AW-1:0]),
    .offset_i(offset_i), .ea_o(ea_d)
  );

  lsu_fmt_store #(.XLEN(XLEN)) u_store (
    .data_i(data_q), .off_i(ea_q[OFFW-1:0]), .size_i(size_q),
    .be_o(be_wide), .wdata_o(wd_wide)
  );

  assign split    = |be_wide[2*LANES-1:LANES];
  assign ld_beats = split ? {mem_rdata_i, lo_q} : {{XLEN{1'b0}}, mem_rdata_i};

  lsu_fmt_load #(.XLEN(XLEN)) u_load (
    .beats_i(ld_beats), .off_i(ea_q[OFFW-1:0]), .size_i(size_q),
    .sgn_i(sgn_q), .val_o(ld_val)
  );

  assign beat_addr   = {ea_q[AW-1:OFFW], {OFFW{1'b0}}};
  assign op_ready_o  = (state_q == ST_IDLE);
  assign mem_valid_o = (state_q == ST_REQ0) || (state_q == ST_REQ1);
  assign mem_we_o    = mem_valid_o & store_q;
  assign mem_addr_o  = (state_q == ST_REQ1) ? beat_addr + AW'(LANES) : beat_addr;
  assign mem_be_o    = (state_q == ST_REQ1) ? be_wide[2*LANES-1:LANES] : be_wide[LANES-1:0];
  assign mem_wdata_o = (state_q == ST_REQ1) ? wd_wide[2*XLEN-1:XLEN] : wd_wide[XLEN-1:0];
  assign wb_valid_o  = wb_valid_q;
  assign wb_data_o   = wb_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ea_q       <= '0;
      size_q     <= '0;
      sgn_q      <= 1'b0;
      store_q    <= 1'b0;
      data_q     <= '0;
      lo_q       <= '0;
      rd_pend_q  <= 1'b0;
      wb_valid_q <= 1'b0;
      wb_data_q  <= '0;
    end else begin
      rd_pend_q  <= mem_valid_o & mem_ready_i & ~store_q;
      wb_valid_q <= (state_q == ST_WAIT);
      // first beat data is live only in the cycle after its accept
      if (rd_pend_q && state_q == ST_REQ1) lo_q <= mem_rdata_i;
      if (state_q == ST_WAIT) wb_data_q <= ld_val;
      unique case (state_q)
        ST_IDLE: if (op_valid_i) begin
          ea_q    <= ea_d;
          size_q  <= op_size_i;
          sgn_q   <= op_signed_i;
          store_q <= op_store_i;
          data_q  <= op_imm_data_i ? XLEN'($signed(src_imm_i)) : src_i;
          state_q <= ST_REQ0;
        end
        ST_REQ0: if (mem_ready_i)
          state_q <= split ? ST_REQ1 : (store_q ? ST_IDLE : ST_WAIT);
        ST_REQ1: if (mem_ready_i)
          state_q <= store_q ? ST_IDLE : ST_WAIT;
        ST_WAIT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_beat_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_addr_o[OFFW-1:0] == '0));

  assert_lanes_present_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_be_o != '0));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_be_o) && $stable(mem_wdata_o)));

  assert_idle_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ready_o |-> !mem_valid_o);

  assert_wb_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o);

  assert_store_no_wb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o) |=> !wb_valid_o);
endmodule

// File: tb/lsu_fmt_tb.sv
module lsu_fmt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        op_valid = 1'b0, op_store = 1'b0, op_signed = 1'b0;
  logic        op_indirect = 1'b0, op_imm_data = 1'b0;
  logic [1:0]  op_size = '0;
  logic [63:0] base = '0, src = '0;
  logic [31:0] offset = '0, src_imm = '0;
  logic        op_ready, mem_valid, mem_ready, mem_we, wb_valid;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata, wb_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .op_store_i(op_store), .op_size_i(op_size), .op_signed_i(op_signed),
    .op_indirect_i(op_indirect), .op_imm_data_i(op_imm_data), .base_i(base),
    .offset_i(offset), .src_i(src), .src_imm_i(src_imm), .mem_valid_o(mem_valid),
    .mem_ready_i(mem_ready), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .wb_valid_o(wb_valid), .wb_data_o(wb_data)
  );

  // memory model: 64 bytes, index by address bits [5:0]
  logic [7:0]  mem_b [64];
  logic [63:0] rdata_q = '0;
  logic        ready_q = 1'b1;
  logic        stall_en = 1'b0;
  int          cyc = 0, hs_cyc = 0, beat_tot = 0;
  logic [31:0] beat_addr_log [16];
  logic [7:0]  beat_be_log [16];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [7:0]  prev_be = '0;
  int          mon_checks = 0, mon_fails = 0;
  int          checks = 0, fails = 0;
  logic        wd_fail = 1'b0;

  assign mem_ready = ready_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    ready_q <= stall_en ? ~ready_q : 1'b1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem_b[i] <= 8'(i * 37 + 11);
    end else begin
      if (prev_stall) begin
        mon_checks <= mon_checks + 1;
        if (!(mem_valid && mem_addr == prev_addr && mem_be == prev_be)) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL R8: held request changed valid=%0b addr=%h be=%h exp addr=%h be=%h",
                   mem_valid, mem_addr, mem_be, prev_addr, prev_be);
        end
      end
      prev_stall <= mem_valid && !mem_ready;
      prev_addr  <= mem_addr;
      prev_be    <= mem_be;
      if (mem_valid && mem_ready) begin
        beat_addr_log[beat_tot % 16] <= mem_addr;
        beat_be_log[beat_tot % 16]   <= mem_be;
        beat_tot <= beat_tot + 1;
        hs_cyc   <= cyc;
        if (mem_we) begin
          for (int k = 0; k < 8; k++)
            if (mem_be[k]) mem_b[6'(mem_addr[5:0] + 6'(k))] <= mem_wdata[8*k +: 8];
        end else begin
          for (int k = 0; k < 8; k++)
            rdata_q[8*k +: 8] <= mem_b[6'(mem_addr[5:0] + 6'(k))];
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             checks + mon_checks + int'(wd_fail), fails + mon_fails + int'(wd_fail));
  endtask

  task automatic run_op(input bit st, input logic [1:0] sz, input bit sg, input bit ind,
                        input bit immd, input logic [63:0] b, input logic [31:0] off,
                        input logic [63:0] s, input logic [31:0] simm, input string tag);
    logic [31:0] ea;
    int          n, b0, nb_exp, lane0;
    logic [7:0]  snap [8];
    logic [63:0] sdat, exp_v;
    logic [15:0] mwide;
    bit          saw_wb;
    ea = (ind ? b[31:0] : 32'h0) + off;
    n  = 1 << sz;
    lane0 = int'(ea[2:0]);
    for (int i = 0; i < 8; i++) snap[i] = mem_b[6'(ea[5:0] + 6'(i))];
    sdat   = immd ? {{32{simm[31]}}, simm} : s;
    nb_exp = (lane0 + n > 8) ? 2 : 1;
    mwide  = ((16'h1 << n) - 16'h1) << lane0;
    @(negedge clk);
    b0 = beat_tot;
    op_valid = 1'b1; op_store = st; op_size = sz; op_signed = sg; op_indirect = ind;
    op_imm_data = immd; base = b; offset = off; src = s; src_imm = simm;
    @(negedge clk);
    op_valid = 1'b0;
    check(op_ready == 1'b0, {tag, " R8 busy"}, 64'(op_ready), 64'd0);
    saw_wb = 1'b0;
    if (st) begin
      while (!op_ready) begin
        if (wb_valid) saw_wb = 1'b1;
        @(negedge clk);
      end
      check(!saw_wb && !wb_valid, {tag, " R9 store no wb"}, 64'(saw_wb), 64'd0);
      for (int i = 0; i < 8; i++)
        check(mem_b[6'(ea[5:0] + 6'(i))] == ((i < n) ? sdat[8*i +: 8] : snap[i]),
              {tag, " R4 R5 stored byte"}, 64'(mem_b[6'(ea[5:0] + 6'(i))]),
              64'((i < n) ? sdat[8*i +: 8] : snap[i]));
    end else begin
      while (!wb_valid) @(negedge clk);
      exp_v = '0;
      for (int i = 0; i < 8; i++) if (i < n) exp_v[8*i +: 8] = snap[i];
      if (sg && n < 8)
        for (int i = 0; i < 64; i++) if (i >= 8*n) exp_v[i] = exp_v[8*n-1];
      check(wb_data == exp_v, {tag, " R6 R7 load value"}, wb_data, exp_v);
      check(cyc - hs_cyc == 2, {tag, " R9 wb timing"}, 64'(cyc - hs_cyc), 64'd2);
      @(negedge clk);
      check(!wb_valid, {tag, " R9 wb pulse"}, 64'(wb_valid), 64'd0);
    end
    check(beat_tot - b0 == nb_exp, {tag, " R3 beat count"}, 64'(beat_tot - b0), 64'(nb_exp));
    check(beat_addr_log[b0 % 16] == {ea[31:3], 3'b000}, {tag, " R1 R2 beat0 addr"},
          64'(beat_addr_log[b0 % 16]), 64'({ea[31:3], 3'b000}));
    check(beat_be_log[b0 % 16] == mwide[7:0], {tag, " R3 beat0 lanes"},
          64'(beat_be_log[b0 % 16]), 64'(mwide[7:0]));
    if (nb_exp == 2) begin
      check(beat_addr_log[(b0 + 1) % 16] == {ea[31:3], 3'b000} + 32'd8, {tag, " R3 beat1 addr"},
            64'(beat_addr_log[(b0 + 1) % 16]), 64'({ea[31:3], 3'b000} + 32'd8));
      check(beat_be_log[(b0 + 1) % 16] == mwide[15:8], {tag, " R3 beat1 lanes"},
            64'(beat_be_log[(b0 + 1) % 16]), 64'(mwide[15:8]));
    end
  endtask

  task automatic t_reset();
    check(op_ready == 1'b1, "R10 op_ready", 64'(op_ready), 64'd1);
    check(mem_valid == 1'b0, "R10 mem_valid", 64'(mem_valid), 64'd0);
    check(wb_valid == 1'b0, "R10 wb_valid", 64'(wb_valid), 64'd0);
  endtask

  task automatic t_aligned();
    run_op(1, 2'd3, 0, 0, 1, '0, 32'h20, '0, 32'hFFFF_FFFE, "store imm d R5");
    run_op(0, 2'd0, 1, 0, 0, '0, 32'h20, '0, '0, "load s8 R6");
    run_op(0, 2'd0, 0, 0, 0, '0, 32'h20, '0, '0, "load u8 R6");
    run_op(0, 2'd1, 1, 0, 0, '0, 32'h20, '0, '0, "load s16 R6");
    run_op(0, 2'd2, 1, 0, 0, '0, 32'h20, '0, '0, "load s32 R6");
    run_op(0, 2'd2, 0, 0, 0, '0, 32'h20, '0, '0, "load u32 R6");
    run_op(0, 2'd3, 1, 0, 0, '0, 32'h18, '0, '0, "load d R6");
  endtask

  task automatic t_stores();
    run_op(1, 2'd2, 0, 0, 0, '0, 32'h8, 64'hDEAD_BEEF_8123_4567, '0, "store w upper ignored R4");
    run_op(0, 2'd3, 0, 0, 0, '0, 32'h8, '0, '0, "readback d R4");
    run_op(1, 2'd0, 0, 0, 1, '0, 32'h11, '0, 32'h0000_0080, "store imm b R5");
    run_op(1, 2'd3, 0, 0, 0, '0, 32'h30, 64'h0123_4567_89AB_CDEF, '0, "store d R4");
  endtask

  task automatic t_addr();
    run_op(0, 2'd3, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFF8, 32'h10, '0, '0, "wrap base R1");
    run_op(0, 2'd2, 1, 1, 0, 64'h1234_5678_0000_0020, 32'hFFFF_FFF8, '0, '0, "neg offset R1");
    run_op(1, 2'd1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hABCD_0034, 64'h5A5A, '0, "absolute R1");
  endtask

  task automatic t_unaligned(input string tag);
    run_op(0, 2'd3, 0, 0, 0, '0, 32'h25, '0, '0, {tag, " split d R7"});
    run_op(0, 2'd2, 1, 1, 0, 64'h10, 32'h6, '0, '0, {tag, " split s32 R7"});
    run_op(1, 2'd3, 0, 0, 0, '0, 32'h3B, 64'hFEDC_BA98_7654_3210, '0, {tag, " split store R3"});
    run_op(0, 2'd3, 0, 0, 0, '0, 32'h3B, '0, '0, {tag, " split readback R7"});
    run_op(1, 2'd1, 0, 0, 0, '0, 32'h0F, 64'hFFFF_FFFF_FFFF_C3A5, '0, {tag, " split h store R3"});
    run_op(0, 2'd1, 1, 0, 0, '0, 32'h0F, '0, '0, {tag, " split s16 R7"});
    run_op(0, 2'd3, 0, 1, 0, 64'h0000_0000_FFFF_FFFC, 32'h0, '0, '0, {tag, " split wrap R1"});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_stores();
    t_addr();
    t_unaligned("ready");
    stall_en = 1'b1;
    t_unaligned("stall R8");
    t_stores();
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule